// File: doc/BRIEF.md
# LIN Protected Identifier Parity Checker

This block sits behind a LIN receiver's byte assembler and examines the protected identifier that opens each frame header. The byte arrives fully assembled, least significant bit first on the wire, so the six identifier bits occupy bits 0 to 5 and the two parity bits occupy bits 6 and 7. When the byte is flagged as belonging to the header, the block always latches it into a PID register. If checking is switched on, it also compares both parity bits against the values computed from the identifier.

A correct identifier, or any identifier taken while checking is off, raises a one-cycle receive-complete interrupt. A parity failure raises a one-cycle status interrupt in its place and sets a sticky error flag. The identifier is still latched, so software can inspect the faulty value. Software clears the flag with a one-cycle clear strobe. Checking is active only when the enable bit and the automatic baud rate mode qualifier are both high.

Top module: `lin_pid_checker`

## Requirements
- R1: After reset, `pid_q` is 0x00, `par_err` is 0, and both interrupt outputs are 0.
- R2: Bits 0 to 5 of the byte are the identifier. Bit 6 must equal the XOR of identifier bits 0, 1, 2 and 4. Bit 7 must equal the inverted XOR of identifier bits 1, 3, 4 and 5.
- R3: A `rx_strobe` with `hdr_phase` high loads `rx_byte` into `pid_q` on that clock edge, whether or not the parity is correct.
- R4: When checking is active and either parity bit is wrong, `par_err` is 1 from the cycle after the strobe.
- R5: A parity failure produces a one-cycle `irq_status` pulse in the cycle after the strobe and no `irq_rx_done`; the two pulses are never high together.
- R6: A stored identifier with correct parity produces exactly one one-cycle `irq_rx_done` pulse in the cycle after the strobe.
- R7: Checking is active only when `chk_en` and `auto_baud` are both 1. Otherwise a bad-parity identifier is stored, gives `irq_rx_done`, and leaves `par_err` unchanged.
- R8: A `rx_strobe` with `hdr_phase` low leaves `pid_q` unchanged and produces no interrupt pulse.
- R9: `err_clr` clears `par_err` on the next edge. If a new parity failure arrives in the same cycle, the set wins and `par_err` stays 1.
- R10: `par_err` stays 1 across later identifiers that have correct parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_strobe | input | 1 | Assembled byte valid, one cycle |
| rx_byte | input | 8 | Assembled received byte |
| hdr_phase | input | 1 | Byte is the header identifier |
| chk_en | input | 1 | Parity check enable |
| auto_baud | input | 1 | Unit is in automatic baud rate mode |
| err_clr | input | 1 | Clear strobe for the parity error flag |
| pid_q | output | 8 | Stored protected identifier |
| par_err | output | 1 | Sticky identifier parity error flag |
| irq_rx_done | output | 1 | Receive-complete interrupt pulse |
| irq_status | output | 1 | Status interrupt pulse |

## Verification
A wrong parity decision shows up one cycle after the strobe, because the wrong interrupt line pulses at that point. A stuck or wrongly cleared error flag is visible on `par_err` on the following edge. A misrouted event, such as both pulses, none, or a pulse longer than one cycle, is caught by sampling both interrupt lines in the cycle after each strobe and again one cycle later. The bench sweeps all 64 identifiers with correct and corrupted parity bits, so a wrong tap in either parity equation appears on the first identifier that depends on that tap.

// File: rtl/lin_pid_pkg.sv
package lin_pid_pkg;
  localparam int ID_W  = 6;
  localparam int PID_W = 8;

  // Expected {P1, P0} for a six-bit identifier
  function automatic logic [1:0] pid_parity_bits(input logic [ID_W-1:0] id);
    logic p0;
    logic p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0};
  endfunction

  function automatic logic pid_parity_bad(input logic [PID_W-1:0] pid);
    return pid[PID_W-1:ID_W] != pid_parity_bits(pid[ID_W-1:0]);
  endfunction
endpackage

// File: rtl/pid_parity_eval.sv
module pid_parity_eval
  import lin_pid_pkg::*;
(
  input  logic [PID_W-1:0] pid,
  input  logic             chk_en,
  input  logic             auto_baud,
  output logic             check_active,
  output logic             parity_bad
);
  always_comb begin
    check_active = chk_en & auto_baud;
    parity_bad   = check_active & pid_parity_bad(pid);
  end
endmodule

// File: rtl/pid_event_router.sv
module pid_event_router
  import lin_pid_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_evt,
  input  logic             parity_bad,
  input  logic             check_active,
  input  logic [PID_W-1:0] rx_byte,
  input  logic             err_clr,
  output logic [PID_W-1:0] pid_q,
  output logic             par_err,
  output logic             irq_rx_done,
  output logic             irq_status
);
  logic err_set;
  logic ok_evt;

  always_comb begin
    err_set = store_evt & parity_bad;
    ok_evt  = store_evt & ~parity_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pid_q       <= '0;
      par_err     <= 1'b0;
      irq_rx_done <= 1'b0;
      irq_status  <= 1'b0;
    end else begin
      if (store_evt) pid_q <= rx_byte;
      if (err_set)      par_err <= 1'b1;
      else if (err_clr) par_err <= 1'b0;
      irq_rx_done <= ok_evt;
      irq_status  <= err_set;
    end
  end

  AST_PID_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> pid_q == $past(rx_byte)); // R3
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> par_err); // R4
  AST_STATUS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> irq_status && !irq_rx_done); // R5
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_status && irq_rx_done)); // R5
  AST_DONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    ok_evt |=> irq_rx_done && !irq_status); // R6
  AST_INACTIVE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt && !check_active |=> irq_rx_done && par_err == $past(par_err)); // R7
  AST_NO_EVT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !store_evt |=> !irq_rx_done && !irq_status && $stable(pid_q)); // R8
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !err_set |=> !par_err); // R9
endmodule

// File: rtl/lin_pid_checker.sv
module lin_pid_checker
  import lin_pid_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_strobe,
  input  logic [PID_W-1:0] rx_byte,
  input  logic             hdr_phase,
  input  logic             chk_en,
  input  logic             auto_baud,
  input  logic             err_clr,
  output logic [PID_W-1:0] pid_q,
  output logic             par_err,
  output logic             irq_rx_done,
  output logic             irq_status
);
  logic store_evt;
  logic check_active;
  logic parity_bad;

  assign store_evt = rx_strobe & hdr_phase;

  pid_parity_eval u_eval (
    .pid          (rx_byte),
    .chk_en       (chk_en),
    .auto_baud    (auto_baud),
    .check_active (check_active),
    .parity_bad   (parity_bad)
  );

  pid_event_router u_route (
    .clk          (clk),
    .rst_n        (rst_n),
    .store_evt    (store_evt),
    .parity_bad   (parity_bad),
    .check_active (check_active),
    .rx_byte      (rx_byte),
    .err_clr      (err_clr),
    .pid_q        (pid_q),
    .par_err      (par_err),
    .irq_rx_done  (irq_rx_done),
    .irq_status   (irq_status)
  );
endmodule

// File: tb/tb_lin_pid_checker.sv
`timescale 1ns/1ps
module tb_lin_pid_checker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_strobe = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       hdr_phase = 1'b0;
  logic       chk_en = 1'b0;
  logic       auto_baud = 1'b0;
  logic       err_clr = 1'b0;
  logic [7:0] pid_q;
  logic       par_err;
  logic       irq_rx_done;
  logic       irq_status;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lin_pid_checker dut (
    .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
    .hdr_phase(hdr_phase), .chk_en(chk_en), .auto_baud(auto_baud),
    .err_clr(err_clr), .pid_q(pid_q), .par_err(par_err),
    .irq_rx_done(irq_rx_done), .irq_status(irq_status)
  );

  // Masked parity, written independently of the design's form (R2)
  function automatic logic bench_bad(input logic [7:0] b);
    logic e0;
    logic e1;
    e0 = ^(b & 8'h17);
    e1 = ~(^(b & 8'h3A));
    return (b[6] != e0) || (b[7] != e1);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Strobe one byte; returns at the negedge where the registered result is visible
  task automatic send(input logic [7:0] b, input logic hdr, input logic clr);
    @(negedge clk);
    rx_byte = b; hdr_phase = hdr; rx_strobe = 1'b1; err_clr = clr;
    @(negedge clk);
    rx_strobe = 1'b0; hdr_phase = 1'b0; err_clr = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  // {chk_en, auto_baud, byte}
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    {2'b11, 8'h80}, {2'b11, 8'h00}, {2'b11, 8'hC1}, {2'b11, 8'h41},
    {2'b11, 8'h3C}, {2'b11, 8'hBC}, {2'b10, 8'h00}, {2'b01, 8'h00},
    {2'b00, 8'hFF}, {2'b11, 8'hFF}, {2'b10, 8'h80}, {2'b11, 8'h7F}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pid_q", pid_q, 8'h00);
    chk("R1 par_err", {7'b0, par_err}, 8'h00);
    chk("R1 irqs", {6'b0, irq_rx_done, irq_status}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic act;
      logic bad;
      clear_flag();
      chk_en = VEC[i][9]; auto_baud = VEC[i][8];
      act = VEC[i][9] & VEC[i][8];
      bad = act & bench_bad(VEC[i][7:0]);
      send(VEC[i][7:0], 1'b1, 1'b0);
      chk("R3 stored", pid_q, VEC[i][7:0]);
      chk("R4/R7 flag", {7'b0, par_err}, {7'b0, bad});
      chk("R5 status", {7'b0, irq_status}, {7'b0, bad});
      chk("R6 done", {7'b0, irq_rx_done}, {7'b0, ~bad});
      @(negedge clk);
      chk("R5/R6 one cycle", {6'b0, irq_rx_done, irq_status}, 8'h00);
    end

    // R2 sweep: every identifier with correct and corrupted parity
    chk_en = 1'b1; auto_baud = 1'b1;
    for (int id = 0; id < 64; id++) begin
      logic [7:0] g;
      g = 8'(id);
      g[6] = g[0] ^ g[1] ^ g[2] ^ g[4];
      g[7] = ~(g[1] ^ g[3] ^ g[4] ^ g[5]);
      clear_flag();
      send(g, 1'b1, 1'b0);
      chk("R2 good id", {6'b0, irq_rx_done, par_err}, 8'h02);
      send(g ^ 8'h40, 1'b1, 1'b0);
      chk("R2 bad P0", {6'b0, irq_status, par_err}, 8'h03);
      clear_flag();
      send(g ^ 8'h80, 1'b1, 1'b0);
      chk("R2 bad P1", {6'b0, irq_status, par_err}, 8'h03);
    end

    // R8: byte outside header is ignored
    clear_flag();
    send(8'h80, 1'b1, 1'b0);
    send(8'h00, 1'b0, 1'b0);
    chk("R8 pid kept", pid_q, 8'h80);
    chk("R8 no irq", {6'b0, irq_rx_done, irq_status}, 8'h00);
    chk("R8 no flag", {7'b0, par_err}, 8'h00);

    // R10: flag sticky over good identifier
    send(8'h00, 1'b1, 1'b0);
    send(8'h80, 1'b1, 1'b0);
    chk("R10 sticky", {6'b0, irq_rx_done, par_err}, 8'h03);

    // R9: clear alone, then clear colliding with new error
    clear_flag();
    chk("R9 cleared", {7'b0, par_err}, 8'h00);
    send(8'h00, 1'b1, 1'b1);
    chk("R9 set wins", {7'b0, par_err}, 8'h01);
    clear_flag();
    chk("R9 cleared again", {7'b0, par_err}, 8'h00);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule